// File: doc/BRIEF.md
# Length-Prefixed Packet Store-and-Forward Buffer

This block sits between a 16-bit packet producer and a 16-bit packet consumer. Both sides use a strobe/acknowledge handshake, and a word moves on the rising clock edge where both are high. Each packet opens with a header word that holds the payload size in bytes. The payload words follow the header. The number of payload words is the byte size divided by two, rounded up. For an odd byte size, the low byte of the final word is padding.

The buffer takes each packet word by word into an internal register file. It counts complete packets as the last word of each one is written. The output side raises its strobe only while at least one complete packet is stored. It then replays each packet verbatim, header first, so a consumer never sees a packet that is still arriving.

The capacity, in words, is set at elaboration time. A header that announces a packet too large to fit raises a sticky error flag. Such a packet cannot complete, so the input stalls until reset.

Top module: `pkt_sf_buffer`

## Requirements
- R1: A word moves on an input or output port only at a rising clock edge where that port's strobe and acknowledge are both 1; both ports are 16 bits wide.
- R2: A header word holding byte count B is followed by ceil(B/2) payload words; for odd B the last word is passed through unchanged, padding byte included.
- R3: Packets leave in arrival order, each replayed word for word with its header first and identical data values.
- R4: out_stb_o is 1 only while at least one complete packet is stored, so no word of a partly received packet is ever presented.
- R5: A header with byte count 0 is a complete one-word packet and is forwarded alone.
- R6: Once out_stb_o is 1, it stays 1 with unchanged out_data_o until the word is accepted.
- R7: in_ack_o is 0 while DEPTH words are stored; once in_ack_o is 1, it stays 1 until a word is taken.
- R8: With a complete packet stored and out_ack_i held at 1, the packet's words leave on consecutive cycles with no gaps.
- R9: While rst_ni is low, in_ack_o and out_stb_o are 0; reset discards all stored words, including a partly received packet.
- R10: Accepting a header whose payload word count is DEPTH or more sets overflow_o; it stays 1 until reset, and a packet of exactly DEPTH words in total leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 16 | Input stream word (header or payload) |
| in_stb_i | input | 1 | Input word valid |
| in_ack_o | output | 1 | Buffer ready to take an input word |
| out_data_o | output | 16 | Output stream word |
| out_stb_o | output | 1 | Output word valid |
| out_ack_i | input | 1 | Consumer ready to take an output word |
| overflow_o | output | 1 | Sticky flag: a header announced a packet larger than the buffer |

## Verification
The hardest state to reach is a full buffer holding exactly one maximum-size packet, where in_ack_o must drop and stay low. The bench reaches it by holding out_ack_i low while it sends a packet of exactly DEPTH words. It then releases the consumer and checks that in_ack_o recovers. A sweep of every byte count that fits, under several consumer stall patterns, makes output replay overlap the arrival of the next packet. That overlap is where an early strobe or a framing miscount would show. Reset in the middle of a packet and headers just over capacity cover the remaining edges.

// File: rtl/pkt_sf_pkg.sv
package pkt_sf_pkg;
  localparam int unsigned WORD_W = 16;

  // payload words for a byte count: ceil(nbytes / 2)
  function automatic logic [WORD_W-1:0] payload_words(input logic [WORD_W-1:0] nbytes);
    logic [WORD_W:0] t;
    t = {1'b0, nbytes} + {{WORD_W{1'b0}}, 1'b1};
    return t[WORD_W:1];
  endfunction
endpackage

// File: rtl/pkt_sf_mem.sv
module pkt_sf_mem #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // async read: the slot under the read pointer is never overwritten while occupied
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pkt_frame_track.sv
module pkt_frame_track
  import pkt_sf_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         xfer_i,
  input  logic [W-1:0] word_i,
  output logic         is_hdr_o,
  output logic         last_o
);
  logic         in_body_q;
  logic [W-1:0] rem_q;
  logic [W-1:0] hdr_words;

  assign hdr_words = payload_words(word_i);
  assign is_hdr_o  = !in_body_q;
  assign last_o    = xfer_i && (in_body_q ? (rem_q == W'(1)) : (hdr_words == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_body_q <= 1'b0;
      rem_q     <= '0;
    end else if (xfer_i) begin
      if (!in_body_q) begin
        in_body_q <= (hdr_words != '0);
        rem_q     <= hdr_words;
      end else begin
        if (rem_q == W'(1)) in_body_q <= 1'b0;
        rem_q <= rem_q - W'(1);
      end
    end
  end
endmodule

// File: rtl/pkt_sf_buffer.sv
module pkt_sf_buffer
  import pkt_sf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_stb_i,
  output logic              in_ack_o,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_stb_o,
  input  logic              out_ack_i,
  output logic              overflow_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] used_q, used_nxt;
  logic [CW-1:0] pkt_q, pkt_nxt;
  logic          ack_q, ovf_q;
  logic          wr_xfer, rd_xfer;
  logic          wr_hdr, wr_last, rd_hdr, rd_last;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign wr_xfer = in_stb_i && in_ack_o;
  assign rd_xfer = out_stb_o && out_ack_i;

  pkt_sf_mem #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk_i   (clk_i),
    .we_i    (wr_xfer),
    .waddr_i (wptr_q),
    .wdata_i (in_data_i),
    .raddr_i (rptr_q),
    .rdata_o (out_data_o)
  );

  pkt_frame_track #(.W(WORD_W)) wr_trk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (wr_xfer),
    .word_i   (in_data_i),
    .is_hdr_o (wr_hdr),
    .last_o   (wr_last)
  );

  pkt_frame_track #(.W(WORD_W)) rd_trk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (rd_xfer),
    .word_i   (out_data_o),
    .is_hdr_o (rd_hdr),
    .last_o   (rd_last)
  );

  assign used_nxt = used_q + CW'(wr_xfer) - CW'(rd_xfer);
  assign pkt_nxt  = pkt_q + CW'(wr_last) - CW'(rd_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      used_q <= '0;
      pkt_q  <= '0;
      ack_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_xfer) wptr_q <= ptr_inc(wptr_q);
      if (rd_xfer) rptr_q <= ptr_inc(rptr_q);
      used_q <= used_nxt;
      pkt_q  <= pkt_nxt;
      // registered ready: can only fall through a write, so it holds until a word is taken
      ack_q  <= (used_nxt < CW'(DEPTH));
      if (wr_xfer && wr_hdr && (32'(payload_words(in_data_i)) >= DEPTH)) ovf_q <= 1'b1;
    end
  end

  assign in_ack_o   = ack_q;
  assign out_stb_o  = (pkt_q != '0);
  assign overflow_o = ovf_q;

  logic unused_rd_hdr;
  assign unused_rd_hdr = rd_hdr;
endmodule

// File: rtl/pkt_sf_buffer_chk.sv
module pkt_sf_buffer_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_stb_i,
  input logic          in_ack_o,
  input logic          out_stb_o,
  input logic          out_ack_i,
  input logic [15:0]   out_data_o,
  input logic          overflow_o,
  input logic [CW-1:0] used_i,
  input logic [CW-1:0] pkt_i
);
  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_stb_o && !out_ack_i |=> out_stb_o && $stable(out_data_o));

  // R7
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o && !in_stb_i |=> in_ack_o);

  // R7
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_i == CW'(DEPTH)) |-> !in_ack_o);

  // R4
  stb_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_stb_o |-> (used_i != '0) && (pkt_i <= used_i));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R1
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_i == '0) |-> !out_stb_o);
endmodule

bind pkt_sf_buffer pkt_sf_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_stb_i   (in_stb_i),
  .in_ack_o   (in_ack_o),
  .out_stb_o  (out_stb_o),
  .out_ack_i  (out_ack_i),
  .out_data_o (out_data_o),
  .overflow_o (overflow_o),
  .used_i     (used_q),
  .pkt_i      (pkt_q)
);

// File: tb/pkt_sf_buffer_tb.sv
module pkt_sf_buffer_tb_top;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        in_stb_i = 1'b0;
  logic        in_ack_o;
  logic [15:0] out_data_o;
  logic        out_stb_o;
  logic        out_ack_i = 1'b0;
  logic        overflow_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  pkt_sf_buffer #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_data_i(in_data_i), .in_stb_i(in_stb_i), .in_ack_o(in_ack_o),
    .out_data_o(out_data_o), .out_stb_o(out_stb_o), .out_ack_i(out_ack_i),
    .overflow_o(overflow_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, ack_mode = 0;
  logic [15:0] exp_q[$];
  int len_q[$];
  int pk_in = 0, pk_out = 0, rem = 0, mon_words = 0;
  bit hdr_phase = 1'b1, prev_hold = 1'b0;
  logic [15:0] prev_data = '0;
  int first_cyc = 0, last_cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(posedge clk_i) begin
    #1;
    case (ack_mode)
      0: out_ack_i = 1'b1;
      1: out_ack_i = 1'b0;
      2: out_ack_i = (cyc % 3) != 0;
      default: out_ack_i = (cyc % 7) < 2;
    endcase
  end

  // output monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_hold) check(out_stb_o === 1'b1 && out_data_o === prev_data, "R6", int'(out_data_o), int'(prev_data));
      if (out_stb_o) check(pk_in > pk_out, "R4", pk_in - pk_out, 1);
      if (out_stb_o && out_ack_i) begin
        logic [15:0] e;
        mon_words++;
        last_cyc = cyc;
        if (exp_q.size() == 0) check(1'b0, "R3", int'(out_data_o), -1);
        else begin
          e = exp_q.pop_front();
          check(out_data_o === e, "R3", int'(out_data_o), int'(e));
        end
        if (hdr_phase) begin
          first_cyc = cyc;
          rem = len_q.pop_front();
          if (rem == 0) pk_out++;
          else hdr_phase = 1'b0;
        end else begin
          rem--;
          if (rem == 0) begin pk_out++; hdr_phase = 1'b1; end
        end
      end
      prev_hold = out_stb_o && !out_ack_i;
      prev_data = out_data_o;
    end
  end

  task automatic sync_pos();
    @(posedge clk_i); #1;
  endtask

  // caller sits just after a rising edge
  task automatic send_word(input logic [15:0] w);
    bit took;
    in_data_i = w;
    in_stb_i  = 1'b1;
    took = 1'b0;
    while (!took) begin
      @(negedge clk_i);
      took = in_ack_o;
      @(posedge clk_i); #1;
    end
  endtask

  task automatic send_pkt(input int nbytes, input int seed);
    int w;
    logic [15:0] d;
    w = (nbytes + 1) / 2;
    len_q.push_back(w);
    exp_q.push_back(16'(nbytes));
    send_word(16'(nbytes));
    for (int i = 0; i < w; i++) begin
      d = 16'(seed * 37 + i * 5 + 1);
      if ((nbytes % 2) == 1 && i == w - 1) d[7:0] = 8'hA5;  // R2 padding byte passes unchanged
      exp_q.push_back(d);
      send_word(d);
    end
    in_stb_i = 1'b0;
    pk_in++;
  endtask

  task automatic wait_drain();
    while (pk_out < pk_in) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni   = 1'b0;
    in_stb_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      check(in_ack_o === 1'b0 && out_stb_o === 1'b0, "R9", int'({in_ack_o, out_stb_o}), 0);
    end
    exp_q.delete(); len_q.delete();
    pk_in = 0; pk_out = 0; rem = 0;
    hdr_phase = 1'b1; prev_hold = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(in_ack_o === 1'b1 && out_stb_o === 1'b0, "R9", int'({in_ack_o, out_stb_o}), 2);
    check(overflow_o === 1'b0, "R10", int'(overflow_o), 0);
  endtask

  initial begin
    int modes[3] = '{0, 2, 3};
    int exp_total;
    int w0;
    do_reset();

    // sweep every byte count that fits, under three consumer patterns (R2, R3, R5, R1)
    mon_words = 0;
    exp_total = 0;
    foreach (modes[m]) begin
      ack_mode = modes[m];
      sync_pos();
      for (int n = 0; n <= 2 * DEPTH - 2; n++) begin
        send_pkt(n, n + m * 100);
        exp_total += 1 + (n + 1) / 2;
      end
      wait_drain();
      check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    end
    check(mon_words == exp_total, "R2", mon_words, exp_total);
    check(overflow_o === 1'b0, "R10", int'(overflow_o), 0);

    // R5: zero-length packet alone
    ack_mode = 0;
    w0 = mon_words;
    sync_pos();
    send_pkt(0, 9);
    wait_drain();
    check(mon_words - w0 == 1, "R5", mon_words - w0, 1);

    // R8: gapless replay
    sync_pos();
    send_pkt(20, 3);
    wait_drain();
    check(last_cyc - first_cyc == 10, "R8", last_cyc - first_cyc, 10);

    // R7: fill exactly to capacity with the consumer stalled
    ack_mode = 1;
    sync_pos();
    send_pkt(2 * DEPTH - 2, 5);
    repeat (3) begin
      @(negedge clk_i);
      check(in_ack_o === 1'b0, "R7", int'(in_ack_o), 0);
      check(out_stb_o === 1'b1, "R4", int'(out_stb_o), 1);
    end
    check(overflow_o === 1'b0, "R10", int'(overflow_o), 0);
    ack_mode = 0;
    wait_drain();
    repeat (4) begin
      @(negedge clk_i);
      check(in_ack_o === 1'b1, "R7", int'(in_ack_o), 1);
    end

    // R9: reset in the middle of a packet discards it
    sync_pos();
    send_word(16'd10);
    send_word(16'h1111);
    send_word(16'h2222);
    in_stb_i = 1'b0;
    @(negedge clk_i);
    check(out_stb_o === 1'b0, "R4", int'(out_stb_o), 0);
    do_reset();
    sync_pos();
    send_pkt(6, 7);
    wait_drain();
    check(pk_out == pk_in && exp_q.size() == 0, "R9", pk_out, pk_in);

    // R10: headers just over capacity
    for (int b = 2 * DEPTH - 1; b <= 2 * DEPTH; b++) begin
      sync_pos();
      send_word(16'(b));
      in_stb_i = 1'b0;
      repeat (3) begin
        @(negedge clk_i);
        check(overflow_o === 1'b1, "R10", int'(overflow_o), 1);
        check(out_stb_o === 1'b0, "R4", int'(out_stb_o), 0);
      end
      do_reset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule